// File: doc/BRIEF.md
# Endian-Selectable Long-Word Read Unpacker

This block sits between the read side of a FIFO that stores 36-bit long words and an 18-bit output port. Each long word is delivered on the port as a run of narrower transfers. There are two port widths. In word width a long word takes two 18-bit transfers. In byte width it takes four 9-bit transfers. The order of the pieces is either most significant first or least significant first.

The width and the piece order are read from two select pins on the first clock edge after reset is released. They stay fixed until the next reset. When a long word is fetched, its first piece goes straight into the output register. The pieces that follow wait in auxiliary registers and are shifted out one per accepted read. The FIFO is popped only when a fresh long word is needed.

The FIFO is of the show-ahead kind: `fifo_rdata` is valid whenever `fifo_empty` is low, and a pop consumes that word on the same clock edge.

Top module: `rd_bus_unpacker`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, `out_ready` and `fifo_pop` are low and `out_data` is zero, even when the FIFO holds data.
- R2: Byte width with most-significant first (`cfg_byte_sel`=1, `cfg_msb_first`=1) presents bits 35:27, then 26:18, then 17:9, then 8:0 on `out_data[8:0]`. `out_data[17:9]` is zero in byte width.
- R3: Byte width with least-significant first (`cfg_byte_sel`=1, `cfg_msb_first`=0) presents bits 8:0, then 17:9, then 26:18, then 35:27 on `out_data[8:0]`.
- R4: Word width with most-significant first (`cfg_byte_sel`=0, `cfg_msb_first`=1) presents bits 35:18, then 17:0 on `out_data[17:0]`.
- R5: Word width with least-significant first (`cfg_byte_sel`=0, `cfg_msb_first`=0) presents bits 17:0, then 35:18.
- R6: `fifo_pop` is raised only when the FIFO is not empty and no piece is held, or when the last piece of the current long word is being read. This gives exactly one pop per long word.
- R7: `out_ready` rises on the clock edge that follows a pop, and it stays low while the FIFO is empty and no piece remains.
- R8: An `out_rd` request made while `out_ready` is low has no effect. No pop happens, `out_data` is unchanged, and the next word still starts with its first piece.
- R9: Changes on `cfg_byte_sel` or `cfg_msb_first` after the first clock edge following reset release are ignored until the next reset.
- R10: When the last piece is read while the FIFO holds another long word, the next word's first piece is presented on the following cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_byte_sel | input | 1 | 1 selects byte width, 0 selects word width; sampled after reset |
| cfg_msb_first | input | 1 | 1 sends the most significant piece first; sampled after reset |
| fifo_empty | input | 1 | FIFO has no long word |
| fifo_rdata | input | 36 | Long word at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head on this edge |
| out_rd | input | 1 | Read request from the port consumer |
| out_ready | output | 1 | A piece is valid on `out_data` |
| out_data | output | 18 | Current piece; bits 17:9 are zero in byte width |

## Verification
The bench builds the block with its default parameters: 9-bit pieces and four pieces per long word. This gives the 36-bit word and the 18-bit port that the requirements describe. With these values, a reset per mode reaches all four width-and-order combinations. It also reaches the two-piece and four-piece boundaries at which a pop must line up with the last read. Both a continuous reader and a sparse pseudo-random reader are used, so back-to-back refills and idle gaps are both covered.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  typedef enum logic {
    WIDTH_WORD = 1'b0,
    WIDTH_BYTE = 1'b1
  } width_e;

  typedef enum logic {
    ORDER_LSB_FIRST = 1'b0,
    ORDER_MSB_FIRST = 1'b1
  } order_e;

  typedef struct packed {
    width_e width;
    order_e order;
  } mode_t;

endpackage

// File: rtl/rbu_mode_latch.sv
module rbu_mode_latch
  import rbu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_byte_i,
  input  logic  sel_msb_i,
  output mode_t mode_o,
  output logic  valid_o
);

  mode_t mode_q, mode_d;
  logic  valid_q, valid_d;

  // Capture the selects once, on the first edge after reset release.
  always_comb begin
    valid_d = 1'b1;
    mode_d  = mode_q;
    if (!valid_q) begin
      mode_d.width = sel_byte_i ? WIDTH_BYTE : WIDTH_WORD;
      mode_d.order = sel_msb_i ? ORDER_MSB_FIRST : ORDER_LSB_FIRST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= '{width: WIDTH_WORD, order: ORDER_LSB_FIRST};
    end else begin
      valid_q <= valid_d;
      mode_q  <= mode_d;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/rbu_sequencer.sv
module rbu_sequencer
  import rbu_pkg::*;
#(
  parameter int PIECE_W    = 9,
  parameter int NUM_PIECES = 4,
  localparam int OUT_W     = 2 * PIECE_W,
  localparam int LW_W      = PIECE_W * NUM_PIECES,
  localparam int HALF      = NUM_PIECES / 2,
  localparam int CNT_W     = $clog2(NUM_PIECES + 1)
)(
  input  logic [LW_W-1:0]                   word_i,
  input  mode_t                             mode_i,
  output logic [NUM_PIECES-1:0][OUT_W-1:0]  seq_o,
  output logic [CNT_W-1:0]                  count_o
);

  localparam int IDX_W = (NUM_PIECES > 1) ? $clog2(NUM_PIECES) : 1;

  logic [NUM_PIECES-1:0][OUT_W-1:0] lane_byte;
  logic [HALF-1:0][OUT_W-1:0]       lane_word;

  // Split the long word into zero-extended byte lanes and word lanes.
  for (genvar g = 0; g < NUM_PIECES; g++) begin : g_byte_lane
    assign lane_byte[g] = {{PIECE_W{1'b0}}, word_i[g*PIECE_W +: PIECE_W]};
  end

  for (genvar g = 0; g < HALF; g++) begin : g_word_lane
    assign lane_word[g] = word_i[g*OUT_W +: OUT_W];
  end

  // Place the lanes in transmit order: slot 0 is presented first.
  always_comb begin
    logic [IDX_W-1:0] idx;
    seq_o = '0;
    for (int i = 0; i < NUM_PIECES; i++) begin
      if (mode_i.width == WIDTH_BYTE) begin
        idx = (mode_i.order == ORDER_MSB_FIRST) ? IDX_W'(NUM_PIECES - 1 - i)
                                                : IDX_W'(i);
        seq_o[i] = lane_byte[idx];
      end else if (i < HALF) begin
        idx = (mode_i.order == ORDER_MSB_FIRST) ? IDX_W'(HALF - 1 - i)
                                                : IDX_W'(i);
        seq_o[i] = lane_word[idx];
      end
    end
  end

  assign count_o = (mode_i.width == WIDTH_BYTE) ? CNT_W'(NUM_PIECES)
                                                : CNT_W'(HALF);

endmodule

// File: rtl/rbu_stage.sv
module rbu_stage #(
  parameter int PIECE_W    = 9,
  parameter int NUM_PIECES = 4,
  localparam int OUT_W     = 2 * PIECE_W,
  localparam int CNT_W     = $clog2(NUM_PIECES + 1)
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_i,
  input  logic                             adv_i,
  input  logic [NUM_PIECES-1:0][OUT_W-1:0] seq_i,
  input  logic [CNT_W-1:0]                 count_i,
  output logic [OUT_W-1:0]                 data_o,
  output logic                             full_o,
  output logic                             last_o
);

  logic [OUT_W-1:0]                  out_q, out_d;
  logic [NUM_PIECES-2:0][OUT_W-1:0]  aux_q, aux_d;
  logic [CNT_W-1:0]                  left_q, left_d;
  logic                              full_q, full_d;
  logic                              out_en, aux_en;

  always_comb begin
    out_d  = out_q;
    aux_d  = aux_q;
    left_d = left_q;
    full_d = full_q;
    out_en = 1'b0;
    aux_en = 1'b0;
    if (load_i) begin
      // First piece goes straight to the output; the rest wait in aux.
      out_d  = seq_i[0];
      aux_d  = seq_i[NUM_PIECES-1:1];
      left_d = count_i - CNT_W'(1);
      full_d = 1'b1;
      out_en = 1'b1;
      aux_en = 1'b1;
    end else if (adv_i) begin
      if (left_q != '0) begin
        out_d  = aux_q[0];
        aux_d  = aux_q >> OUT_W;
        left_d = left_q - CNT_W'(1);
        out_en = 1'b1;
        aux_en = 1'b1;
      end else begin
        full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      aux_q  <= '0;
      left_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      if (aux_en) aux_q <= aux_d;
      left_q <= left_d;
      full_q <= full_d;
    end
  end

  assign data_o = out_q;
  assign full_o = full_q;
  assign last_o = full_q && (left_q == '0);

endmodule

// File: rtl/rd_bus_unpacker.sv
module rd_bus_unpacker
  import rbu_pkg::*;
#(
  parameter int PIECE_W    = 9,
  parameter int NUM_PIECES = 4,
  localparam int OUT_W     = 2 * PIECE_W,
  localparam int LW_W      = PIECE_W * NUM_PIECES
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_byte_sel,
  input  logic             cfg_msb_first,
  input  logic             fifo_empty,
  input  logic [LW_W-1:0]  fifo_rdata,
  output logic             fifo_pop,
  input  logic             out_rd,
  output logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam int CNT_W = $clog2(NUM_PIECES + 1);

  mode_t                            mode;
  logic                             mode_ok;
  logic                             is_byte;
  logic [NUM_PIECES-1:0][OUT_W-1:0] seq;
  logic [CNT_W-1:0]                 count;
  logic                             full;
  logic                             last;
  logic                             take;
  logic                             need_word;

  rbu_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_byte_i (cfg_byte_sel),
    .sel_msb_i  (cfg_msb_first),
    .mode_o     (mode),
    .valid_o    (mode_ok)
  );

  rbu_sequencer #(.PIECE_W(PIECE_W), .NUM_PIECES(NUM_PIECES)) u_seq (
    .word_i  (fifo_rdata),
    .mode_i  (mode),
    .seq_o   (seq),
    .count_o (count)
  );

  rbu_stage #(.PIECE_W(PIECE_W), .NUM_PIECES(NUM_PIECES)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (fifo_pop),
    .adv_i   (take),
    .seq_i   (seq),
    .count_i (count),
    .data_o  (out_data),
    .full_o  (full),
    .last_o  (last)
  );

  assign is_byte   = (mode.width == WIDTH_BYTE);
  assign take      = full && out_rd;
  assign need_word = !full || (take && last);
  assign fifo_pop  = mode_ok && !fifo_empty && need_word;
  assign out_ready = full;

endmodule

// File: rtl/rd_bus_unpacker_chk.sv
module rd_bus_unpacker_chk #(
  parameter int PIECE_W    = 9,
  parameter int NUM_PIECES = 4,
  localparam int OUT_W     = 2 * PIECE_W
)(
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             out_rd,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             mode_ok,
  input logic             is_byte
);

  localparam int CW = $clog2(NUM_PIECES + 1) + 1;

  logic [CW-1:0] rd_since;
  logic [CW-1:0] per_word;

  assign per_word = is_byte ? CW'(NUM_PIECES) : CW'(NUM_PIECES / 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_since <= '0;
    else if (fifo_pop)              rd_since <= '0;
    else if (out_ready && out_rd)   rd_since <= rd_since + CW'(1);
  end

  assert_idle_until_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> (!out_ready && !fifo_pop));

  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && is_byte) |-> (out_data[OUT_W-1:PIECE_W] == '0));

  assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  assert_pop_on_last_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && out_ready) |-> (out_rd && (rd_since + CW'(1) == per_word)));

  assert_ready_after_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> out_ready);

  assert_ignore_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !fifo_pop) |=> (!out_ready && $stable(out_data)));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok |=> ($stable(is_byte) && mode_ok));

  assert_no_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_rd) |-> !fifo_pop);

endmodule

bind rd_bus_unpacker rd_bus_unpacker_chk #(
  .PIECE_W    (PIECE_W),
  .NUM_PIECES (NUM_PIECES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .out_rd     (out_rd),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .mode_ok    (mode_ok),
  .is_byte    (is_byte)
);

// File: tb/sim_rd_bus_unpacker.sv
`timescale 1ns/1ps
module sim_rd_bus_unpacker;

  localparam int PW = 9;
  localparam int NP = 4;
  localparam int OW = 2 * PW;
  localparam int LW = PW * NP;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_byte_sel, cfg_msb_first;
  logic          fifo_empty;
  logic [LW-1:0] fifo_rdata;
  logic          fifo_pop;
  logic          out_rd;
  logic          out_ready;
  logic [OW-1:0] out_data;

  rd_bus_unpacker #(.PIECE_W(PW), .NUM_PIECES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_byte_sel(cfg_byte_sel),
    .cfg_msb_first(cfg_msb_first), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .out_rd(out_rd),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int pops = 0;
  int words = 0;
  int ready_hits = 0;
  int gaps = 0;
  int rd_mode = 0;
  bit reader_en = 1'b0;
  bit pop_seen = 1'b0;
  bit started = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [LW-1:0] fq[$];
  logic [OW-1:0] exp_q[$];
  string         tag_q[$];

  task automatic check(input string req, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_rdata = (fq.size() != 0) ? fq[0] : '0;
  endtask

  // Driver: queue the long word and the pieces it must become.
  task automatic push_word(input logic [LW-1:0] w, input bit bmode,
                           input bit big, input string req);
    fq.push_back(w);
    words++;
    if (bmode) begin
      for (int i = 0; i < NP; i++) begin
        int k = big ? NP - 1 - i : i;
        exp_q.push_back({{PW{1'b0}}, w[k*PW +: PW]});
        tag_q.push_back(req);
      end
    end else begin
      for (int i = 0; i < NP / 2; i++) begin
        int k = big ? NP / 2 - 1 - i : i;
        exp_q.push_back(w[k*OW +: OW]);
        tag_q.push_back(req);
      end
    end
    refresh();
  endtask

  // FIFO model: the pop seen at an edge is applied at the next falling edge.
  always @(posedge clk) pop_seen <= fifo_pop;
  always @(negedge clk) begin
    if (pop_seen) begin
      pops++;
      if (fq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 actual=pop_on_empty expected=no_pop");
      end else begin
        void'(fq.pop_front());
      end
      refresh();
    end
  end

  // Monitor and reader: compare each accepted piece against the scoreboard.
  always @(negedge clk) begin
    bit rd;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd = reader_en && ((rd_mode == 0) || lfsr[0]);
    if (rst_n && out_ready) begin
      ready_hits++;
      started = 1'b1;
    end
    if (rst_n && !out_ready && started && exp_q.size() != 0) gaps++;
    if (rst_n && out_ready && rd) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 actual=%h expected=none", out_data);
      end else begin
        string t = tag_q.pop_front();
        check(t, out_data, exp_q.pop_front());
      end
    end
    out_rd = rd;
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic do_reset(input bit bmode, input bit big,
                          input logic [LW-1:0] preload);
    rst_n = 1'b0;
    reader_en = 1'b0;
    cfg_byte_sel = bmode;
    cfg_msb_first = big;
    fq.delete(); exp_q.delete(); tag_q.delete();
    pops = 0; words = 0;
    refresh();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {16'b0, out_ready, fifo_pop}, '0);
    check("R1", out_data, '0);
    push_word(preload, bmode, big, "R1");
    #0.1;
    rst_n = 1'b1;
    #0.1;
    // Release edge has not yet come: selects not latched, no pop allowed.
    check("R1", {16'b0, out_ready, fifo_pop}, '0);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while ((exp_q.size() != 0 || fq.size() != 0) && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(req, OW'(pops), OW'(words));
    check(req, OW'(exp_q.size()), '0);
  endtask

  task automatic run_mode(input bit bmode, input bit big, input string req);
    do_reset(bmode, big, 36'h9_1234_5678);
    // Flip the selects after release; the latched mode must hold (R9).
    @(posedge clk);
    #1;
    cfg_byte_sel = !bmode;
    cfg_msb_first = !big;
    reader_en = 1'b1;
    rd_mode = 1;
    push_word(36'hF_EDCB_A987, bmode, big, req);
    push_word(36'h0_0000_01FF, bmode, big, req);
    push_word(36'hA_AAAA_5555, bmode, big, "R9");
    drain(req);
  endtask

  initial begin
    rst_n = 1'b0;
    out_rd = 1'b0;
    cfg_byte_sel = 1'b0;
    cfg_msb_first = 1'b0;
    refresh();

    run_mode(1'b1, 1'b1, "R2");
    run_mode(1'b1, 1'b0, "R3");
    run_mode(1'b0, 1'b1, "R4");
    run_mode(1'b0, 1'b0, "R5");

    // R7 and R8: empty FIFO, reads while not ready are ignored.
    do_reset(1'b1, 1'b0, 36'h1_2345_6789);
    reader_en = 1'b1; rd_mode = 0;
    drain("R6");
    begin
      logic [OW-1:0] held;
      held = out_data;
      repeat (6) begin
        @(negedge clk);
        check("R8", {17'b0, out_ready}, '0);
        check("R8", out_data, held);
      end
    end
    check("R7", OW'(pops), OW'(words));
    reader_en = 1'b0;
    @(posedge clk); #1;
    push_word(36'h3_C0DE_F00D, 1'b1, 1'b0, "R8");
    @(negedge clk);
    check("R7", {17'b0, fifo_pop}, 18'd1);
    @(negedge clk);
    check("R7", {17'b0, out_ready}, 18'd1);
    check("R8", out_data, {9'b0, 9'h00D});
    reader_en = 1'b1;
    drain("R7");

    // R10: several words queued, continuous reader, no idle cycle.
    do_reset(1'b0, 1'b1, 36'h7_7777_0000);
    push_word(36'h1_1111_2222, 1'b0, 1'b1, "R10");
    push_word(36'h3_3333_4444, 1'b0, 1'b1, "R10");
    push_word(36'h5_5555_6666, 1'b0, 1'b1, "R10");
    ready_hits = 0; gaps = 0; started = 1'b0;
    rd_mode = 0;
    reader_en = 1'b1;
    drain("R10");
    check("R10", OW'(gaps), '0);
    check("R10", OW'(ready_hits), OW'(8));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule